// File: doc/BRIEF.md
# UART Receive-Timeout Interrupt Controller

This block sits beside a UART receive path and decides when the CPU or a DMA engine should be told about receive and transmit activity. It runs an idle timer that counts bit-time ticks while the receive FIFO holds data. When no new character arrives and nothing is read out for a programmable number of ticks, it raises a receive-timeout event. This lets software collect the tail of a message that never reaches the FIFO threshold.

It keeps three pending flags: receive-timeout, receive and transmit. The receive and transmit events come from the surrounding UART as strobes. A small register bus gives access to the timeout length, an interrupt mask, two DMA trigger masks, the raw flags, an interrupt index and a write-one-to-clear register. The interrupt index reports the most urgent pending, unmasked event, and reading it clears that event. The timeout flag has two further ways to clear: the FIFO draining empty, and a write-one clear. Two separate outputs pulse to start a DMA receive transfer and a DMA transmit transfer.

Top module: `rx_timeout_irq_ctrl`

## Requirements
- R1: After reset all flags are 0, every mask and the timeout length are 0, `irqOut`, `dmaRxTrig` and `dmaTxTrig` are low, and reading the index register returns 0x00.
- R2: Let N be the nonzero timeout length in the config register (address 0, bits [3:0]). While the FIFO is non-empty, the receive-timeout flag (flag bit 0) sets on the clock edge that takes the N-th bit tick since the last character strobe or FIFO read.
- R3: A character strobe or a FIFO read restarts the idle count from zero.
- R4: A timeout length of 0 disables the timeout: the flag never sets, however many ticks arrive.
- R5: The timeout fires at most once per idle period. After it fires, further ticks do not set it again until a character strobe or a FIFO read.
- R6: While the FIFO is empty the timeout flag is cleared and ticks are not counted.
- R7: The index register (address 5) returns 0x01 for receive-timeout, 0x0B for receive (flag bit 1) and 0x0C for transmit (flag bit 2). It reports the pending flag with the lowest code among those enabled in the interrupt mask (address 1, same bit positions). It returns 0x00 when no enabled flag is pending.
- R8: A read of the index register clears exactly the flag it reports and leaves the others pending.
- R9: Writing to the clear register (address 6) clears each flag whose data bit is 1 and leaves flags whose data bit is 0 untouched. The raw flags read back at address 4, with bits [2:0] = transmit, receive, receive-timeout.
- R10: `irqOut` is high exactly when some flag is pending and its interrupt-mask bit is set.
- R11: `dmaRxTrig` (and likewise `dmaTxTrig`) pulses for one cycle, one cycle after an event whose bit is set in the DMA receive mask at address 2 (the DMA transmit mask at address 3). Neither pulse depends on the interrupt mask.
- R12: The config and the three mask registers read back the value written. Read data appears one cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| fifoNotEmpty | input | 1 | Receive FIFO holds at least one entry |
| rxChar | input | 1 | One-cycle strobe: a character entered the FIFO |
| fifoRead | input | 1 | One-cycle strobe: an entry was read from the FIFO or holding register |
| bitTick | input | 1 | One-cycle strobe per bit time |
| rxEvt | input | 1 | Receive event strobe |
| txEvt | input | 1 | Transmit event strobe |
| busAddr | input | ADDR_W | Register address |
| busWe | input | 1 | Write enable |
| busWdata | input | DATA_W | Write data |
| busRe | input | 1 | Read enable |
| busRdata | output | DATA_W | Registered read data |
| irqOut | output | 1 | CPU interrupt request |
| dmaRxTrig | output | 1 | DMA receive transfer trigger pulse |
| dmaTxTrig | output | 1 | DMA transmit transfer trigger pulse |

## Verification
The bench counts ticks exactly on both sides of the timeout length. A timer that fires one tick early or late, or that keeps counting through a character or a FIFO read, shows up as a flag present or absent on the wrong read. It keeps ticking after a timeout to catch a timer that re-arms by itself, and ticks against an empty FIFO and a zero length to catch a timer that ignores those gates. It drains the index register with all three flags pending and again under a partial mask. Wrong priority, clearing the wrong flag, or ignoring the mask would each change the sequence of codes. Finally, it pulses events with the interrupt mask off to show that the DMA triggers follow only their own masks.

// File: rtl/rto_irq_pkg.sv
package rto_irq_pkg;
  localparam int NUM_EVT = 3;
  localparam int EVT_RTO = 0;
  localparam int EVT_RX  = 1;
  localparam int EVT_TX  = 2;
  localparam int IDX_W   = 8;

  localparam int REG_CFG   = 0;
  localparam int REG_IMASK = 1;
  localparam int REG_DMARX = 2;
  localparam int REG_DMATX = 3;
  localparam int REG_RAW   = 4;
  localparam int REG_INDEX = 5;
  localparam int REG_CLEAR = 6;

  typedef struct packed {
    logic [NUM_EVT-1:0] w1cClr;
    logic [NUM_EVT-1:0] idxClr;
  } ctrlStrobes_t;

  function automatic logic [IDX_W-1:0] evtCode(input int evt);
    case (evt)
      EVT_RTO: evtCode = 8'h01;
      EVT_RX:  evtCode = 8'h0B;
      EVT_TX:  evtCode = 8'h0C;
      default: evtCode = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/rto_idle_timer.sv
module rto_idle_timer #(
  parameter int TO_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            fifoNotEmpty,
  input  logic            rxChar,
  input  logic            fifoRead,
  input  logic            bitTick,
  input  logic [TO_W-1:0] toSel,
  output logic            firePulse
);
  logic [TO_W-1:0] idleCnt;
  logic            armed;
  logic            restart;
  logic            countEn;
  logic            atLimit;

  assign restart = rxChar | fifoRead;
  assign countEn = fifoNotEmpty && !restart && bitTick && armed && (toSel != '0);
  assign atLimit = (idleCnt == TO_W'(toSel - 1'b1));
  assign firePulse = countEn && atLimit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleCnt <= '0;
      armed   <= 1'b1;
    end else if (restart) begin
      idleCnt <= '0;
      armed   <= 1'b1;
    end else if (!fifoNotEmpty) begin
      idleCnt <= '0;
    end else if (countEn) begin
      if (atLimit) begin
        idleCnt <= '0;
        armed   <= 1'b0;
      end else begin
        idleCnt <= idleCnt + 1'b1;
      end
    end
  end

  // R3
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> (idleCnt == '0));

  // R5
  once_per_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (firePulse && !restart) |=> !firePulse);
endmodule

// File: rtl/rto_irq_datapath.sv
module rto_irq_datapath
  import rto_irq_pkg::*;
#(
  parameter int TO_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fifoNotEmpty,
  input  logic               rxChar,
  input  logic               fifoRead,
  input  logic               bitTick,
  input  logic               rxEvt,
  input  logic               txEvt,
  input  logic [TO_W-1:0]    toSel,
  input  logic [NUM_EVT-1:0] dmaRxMask,
  input  logic [NUM_EVT-1:0] dmaTxMask,
  input  ctrlStrobes_t       strobes,
  output logic [NUM_EVT-1:0] rawFlags,
  output logic               dmaRxTrig,
  output logic               dmaTxTrig
);
  logic               rtoFire;
  logic [NUM_EVT-1:0] setVec;
  logic [NUM_EVT-1:0] clrVec;

  rto_idle_timer #(.TO_W(TO_W)) u_timer (
    .clk          (clk),
    .rstN         (rstN),
    .fifoNotEmpty (fifoNotEmpty),
    .rxChar       (rxChar),
    .fifoRead     (fifoRead),
    .bitTick      (bitTick),
    .toSel        (toSel),
    .firePulse    (rtoFire)
  );

  always_comb begin
    setVec          = '0;
    setVec[EVT_RTO] = rtoFire;
    setVec[EVT_RX]  = rxEvt;
    setVec[EVT_TX]  = txEvt;
  end

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_flag
    if (i == EVT_RTO) begin : g_rto
      assign clrVec[i] = strobes.w1cClr[i] | strobes.idxClr[i] | ~fifoNotEmpty;
    end else begin : g_other
      assign clrVec[i] = strobes.w1cClr[i] | strobes.idxClr[i];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          rawFlags[i] <= 1'b0;
      else if (setVec[i]) rawFlags[i] <= 1'b1;
      else if (clrVec[i]) rawFlags[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dmaRxTrig <= 1'b0;
      dmaTxTrig <= 1'b0;
    end else begin
      dmaRxTrig <= |(setVec & dmaRxMask);
      dmaTxTrig <= |(setVec & dmaTxMask);
    end
  end

  // R6
  empty_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    !fifoNotEmpty |=> !rawFlags[EVT_RTO]);

  // R2
  rto_needs_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rawFlags[EVT_RTO]) |-> $past(fifoNotEmpty));

  // R11
  dma_rx_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    dmaRxTrig |-> $past(dmaRxMask != '0));
endmodule

// File: rtl/rto_irq_control.sv
module rto_irq_control
  import rto_irq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int TO_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWe,
  input  logic [DATA_W-1:0]  busWdata,
  input  logic               busRe,
  input  logic [NUM_EVT-1:0] rawFlags,
  output logic [DATA_W-1:0]  busRdata,
  output logic [TO_W-1:0]    toSel,
  output logic [NUM_EVT-1:0] irqMask,
  output logic [NUM_EVT-1:0] dmaRxMask,
  output logic [NUM_EVT-1:0] dmaTxMask,
  output ctrlStrobes_t       strobes
);
  logic [NUM_EVT-1:0] pendMasked;
  logic [NUM_EVT-1:0] idxOneHot;
  logic [IDX_W-1:0]   idxCode;
  logic               rdIndex;
  logic               wrClear;
  logic               unusedWdata;

  assign unusedWdata = ^busWdata;
  assign pendMasked  = rawFlags & irqMask;
  assign rdIndex     = busRe && (busAddr == ADDR_W'(REG_INDEX));
  assign wrClear     = busWe && (busAddr == ADDR_W'(REG_CLEAR));

  always_comb begin
    idxOneHot = '0;
    idxCode   = '0;
    for (int i = NUM_EVT - 1; i >= 0; i--) begin
      if (pendMasked[i]) begin
        idxOneHot    = '0;
        idxOneHot[i] = 1'b1;
        idxCode      = evtCode(i);
      end
    end
  end

  assign strobes.idxClr = rdIndex ? idxOneHot : '0;
  assign strobes.w1cClr = wrClear ? busWdata[NUM_EVT-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toSel     <= '0;
      irqMask   <= '0;
      dmaRxMask <= '0;
      dmaTxMask <= '0;
    end else if (busWe) begin
      case (busAddr)
        ADDR_W'(REG_CFG):   toSel     <= busWdata[TO_W-1:0];
        ADDR_W'(REG_IMASK): irqMask   <= busWdata[NUM_EVT-1:0];
        ADDR_W'(REG_DMARX): dmaRxMask <= busWdata[NUM_EVT-1:0];
        ADDR_W'(REG_DMATX): dmaTxMask <= busWdata[NUM_EVT-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdata <= '0;
    end else if (busRe) begin
      case (busAddr)
        ADDR_W'(REG_CFG):   busRdata <= DATA_W'(toSel);
        ADDR_W'(REG_IMASK): busRdata <= DATA_W'(irqMask);
        ADDR_W'(REG_DMARX): busRdata <= DATA_W'(dmaRxMask);
        ADDR_W'(REG_DMATX): busRdata <= DATA_W'(dmaTxMask);
        ADDR_W'(REG_RAW):   busRdata <= DATA_W'(rawFlags);
        ADDR_W'(REG_INDEX): busRdata <= DATA_W'(idxCode);
        default:            busRdata <= '0;
      endcase
    end
  end

  // R8
  index_clear_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes.idxClr));

  // R8
  index_clear_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.idxClr != '0) |-> ((strobes.idxClr & rawFlags & irqMask) == strobes.idxClr));
endmodule

// File: rtl/rx_timeout_irq_ctrl.sv
module rx_timeout_irq_ctrl
  import rto_irq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int TO_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoNotEmpty,
  input  logic              rxChar,
  input  logic              fifoRead,
  input  logic              bitTick,
  input  logic              rxEvt,
  input  logic              txEvt,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busRe,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut,
  output logic              dmaRxTrig,
  output logic              dmaTxTrig
);
  logic [TO_W-1:0]    toSel;
  logic [NUM_EVT-1:0] irqMask;
  logic [NUM_EVT-1:0] dmaRxMask;
  logic [NUM_EVT-1:0] dmaTxMask;
  logic [NUM_EVT-1:0] rawFlags;
  ctrlStrobes_t       strobes;

  rto_irq_control #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TO_W(TO_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWe     (busWe),
    .busWdata  (busWdata),
    .busRe     (busRe),
    .rawFlags  (rawFlags),
    .busRdata  (busRdata),
    .toSel     (toSel),
    .irqMask   (irqMask),
    .dmaRxMask (dmaRxMask),
    .dmaTxMask (dmaTxMask),
    .strobes   (strobes)
  );

  rto_irq_datapath #(.TO_W(TO_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .fifoNotEmpty (fifoNotEmpty),
    .rxChar       (rxChar),
    .fifoRead     (fifoRead),
    .bitTick      (bitTick),
    .rxEvt        (rxEvt),
    .txEvt        (txEvt),
    .toSel        (toSel),
    .dmaRxMask    (dmaRxMask),
    .dmaTxMask    (dmaTxMask),
    .strobes      (strobes),
    .rawFlags     (rawFlags),
    .dmaRxTrig    (dmaRxTrig),
    .dmaTxTrig    (dmaTxTrig)
  );

  assign irqOut = |(rawFlags & irqMask);

  // R10
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rawFlags == '0) |-> !irqOut);
endmodule

// File: tb/tb_rx_timeout_irq_ctrl.sv
module tb_rx_timeout_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fifoNotEmpty = 1'b0;
  logic        rxChar = 1'b0;
  logic        fifoRead = 1'b0;
  logic        bitTick = 1'b0;
  logic        rxEvt = 1'b0;
  logic        txEvt = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic        busRe = 1'b0;
  logic [31:0] busRdata;
  logic        irqOut;
  logic        dmaRxTrig;
  logic        dmaTxTrig;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rx_timeout_irq_ctrl dut (
    .clk(clk), .rstN(rstN), .fifoNotEmpty(fifoNotEmpty), .rxChar(rxChar),
    .fifoRead(fifoRead), .bitTick(bitTick), .rxEvt(rxEvt), .txEvt(txEvt),
    .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata), .busRe(busRe),
    .busRdata(busRdata), .irqOut(irqOut), .dmaRxTrig(dmaRxTrig), .dmaTxTrig(dmaTxTrig)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input int addr, input logic [31:0] data);
    @(negedge clk);
    busAddr = 4'(addr); busWdata = data; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input int addr, output logic [31:0] data);
    @(negedge clk);
    busAddr = 4'(addr); busRe = 1'b1;
    @(negedge clk);
    busRe = 1'b0;
    data = busRdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bitTick = 1'b1;
      @(negedge clk); bitTick = 1'b0;
    end
  endtask

  task automatic charIn();
    @(negedge clk); rxChar = 1'b1;
    @(negedge clk); rxChar = 1'b0;
  endtask

  task automatic readFifo();
    @(negedge clk); fifoRead = 1'b1;
    @(negedge clk); fifoRead = 1'b0;
  endtask

  task automatic clearAll();
    busWrite(6, 32'h7);
  endtask

  task automatic testReset();
    logic [31:0] d;
    @(negedge clk);
    check("R1 irqOut", 32'(irqOut), 0);
    check("R1 dmaRxTrig", 32'(dmaRxTrig), 0);
    check("R1 dmaTxTrig", 32'(dmaTxTrig), 0);
    busRead(4, d); check("R1 raw flags", d, 0);
    busRead(5, d); check("R1 index", d, 0);
    busRead(0, d); check("R1 cfg", d, 0);
  endtask

  task automatic testRegs();
    logic [31:0] d;
    busWrite(1, 32'h5); busRead(1, d); check("R12 imask readback", d, 32'h5);
    busWrite(2, 32'h3); busRead(2, d); check("R12 dmarx readback", d, 32'h3);
    busWrite(3, 32'h6); busRead(3, d); check("R12 dmatx readback", d, 32'h6);
    busWrite(0, 32'h3); busRead(0, d); check("R12 cfg readback", d, 32'h3);
    busWrite(2, 0); busWrite(3, 0); busWrite(1, 0);
  endtask

  task automatic testTimeoutFires();
    logic [31:0] d;
    busWrite(0, 32'h3); busWrite(1, 32'h1);
    fifoNotEmpty = 1'b1;
    charIn();
    ticks(2);
    busRead(4, d); check("R2 no flag after N-1 ticks", d, 0);
    check("R10 irq low before timeout", 32'(irqOut), 0);
    ticks(1);
    busRead(4, d); check("R2 flag after N ticks", d, 32'h1);
    check("R10 irq high on timeout", 32'(irqOut), 1);
    busRead(5, d); check("R7 index code timeout", d, 32'h01);
    busRead(4, d); check("R8 index read clears timeout", d, 0);
    ticks(6);
    busRead(4, d); check("R5 no re-fire while idle", d, 0);
    charIn();
    ticks(3);
    busRead(4, d); check("R5 re-fires after new char", d, 32'h1);
    busWrite(6, 32'h1);
    busRead(4, d); check("R9 write-one clears timeout", d, 0);
  endtask

  task automatic testRestart();
    logic [31:0] d;
    readFifo();
    ticks(2);
    readFifo();
    ticks(2);
    busRead(4, d); check("R3 fifo read restarts count", d, 0);
    charIn();
    ticks(2);
    busRead(4, d); check("R3 char restarts count", d, 0);
    ticks(1);
    busRead(4, d); check("R3 fires N ticks after restart", d, 32'h1);
    fifoNotEmpty = 1'b0;
    @(negedge clk);
    busRead(4, d); check("R6 empty fifo clears timeout", d, 0);
  endtask

  task automatic testEmptyAndZero();
    logic [31:0] d;
    charIn();
    ticks(8);
    busRead(4, d); check("R6 no count while empty", d, 0);
    fifoNotEmpty = 1'b1;
    ticks(2);
    busRead(4, d); check("R6 count starts when non-empty", d, 0);
    ticks(1);
    busRead(4, d); check("R6 fires after N non-empty ticks", d, 32'h1);
    clearAll();
    busWrite(0, 32'h0);
    charIn();
    ticks(20);
    busRead(4, d); check("R4 zero length disables", d, 0);
    busWrite(0, 32'h3);
  endtask

  task automatic testPriority();
    logic [31:0] d;
    busWrite(1, 32'h7);
    charIn();
    ticks(3);
    @(negedge clk); rxEvt = 1'b1; txEvt = 1'b1;
    @(negedge clk); rxEvt = 1'b0; txEvt = 1'b0;
    busRead(4, d); check("R9 raw flags all pending", d, 32'h7);
    busRead(5, d); check("R7 first index timeout", d, 32'h01);
    busRead(5, d); check("R7 second index receive", d, 32'h0B);
    busRead(4, d); check("R8 only receive cleared", d, 32'h4);
    busRead(5, d); check("R7 third index transmit", d, 32'h0C);
    busRead(5, d); check("R7 index empty", d, 32'h00);
    @(negedge clk); rxEvt = 1'b1; txEvt = 1'b1;
    @(negedge clk); rxEvt = 1'b0; txEvt = 1'b0;
    busWrite(1, 32'h4);
    busRead(5, d); check("R7 mask skips receive", d, 32'h0C);
    busRead(4, d); check("R8 masked receive stays", d, 32'h2);
    busRead(5, d); check("R7 masked pending reads zero", d, 32'h00);
    check("R10 irq low when masked", 32'(irqOut), 0);
    busWrite(1, 32'h2);
    check("R10 irq high when unmasked", 32'(irqOut), 1);
    busWrite(6, 32'h4);
    busRead(4, d); check("R9 zero bit leaves flag", d, 32'h2);
    busWrite(6, 32'h2);
    busRead(4, d); check("R9 one bit clears flag", d, 0);
    check("R10 irq low after clear", 32'(irqOut), 0);
  endtask

  task automatic testDma();
    busWrite(1, 32'h0);
    busWrite(2, 32'h2);
    busWrite(3, 32'h4);
    @(negedge clk); rxEvt = 1'b1;
    @(negedge clk); rxEvt = 1'b0;
    check("R11 rx trigger pulses", 32'(dmaRxTrig), 1);
    check("R11 tx trigger quiet on rx", 32'(dmaTxTrig), 0);
    @(negedge clk);
    check("R11 rx trigger one cycle", 32'(dmaRxTrig), 0);
    @(negedge clk); txEvt = 1'b1;
    @(negedge clk); txEvt = 1'b0;
    check("R11 tx trigger pulses", 32'(dmaTxTrig), 1);
    check("R11 rx trigger quiet on tx", 32'(dmaRxTrig), 0);
    check("R11 irq unaffected by dma mask", 32'(irqOut), 0);
    busWrite(2, 32'h0);
    @(negedge clk); rxEvt = 1'b1;
    @(negedge clk); rxEvt = 1'b0;
    check("R11 rx trigger masked off", 32'(dmaRxTrig), 0);
    clearAll();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testRegs();
    testTimeoutFires();
    testRestart();
    testEmptyAndZero();
    testPriority();
    testDma();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule